// File: doc/BRIEF.md
# Handshaked System Clock Source Switch

This block picks the system clock from eight oscillator sources and moves to another one when software asks. Each source arrives as a free-running clock together with a ready flag. Software first opens a two-word key gate and then writes the control word. That word carries a 3-bit requested-source code and a start bit. A request-and-acknowledge sequence then checks that the requested source is ready. It gates the old clock off on that clock's own falling edge and waits until the off state is seen. Only then does it gate the new clock on. The start bit clears itself once the attempt ends, and the current-source field shows whether the switch took place.

The switch sequencer has four states. SW_IDLE goes to SW_CHECK on an admitted write that sets the start bit. From SW_CHECK there are three exits:
- back to SW_IDLE, rejected, when the requested source is not ready;
- back to SW_IDLE, trivially complete, when it is already the current source;
- forward to SW_DROP otherwise.

SW_DROP goes to SW_RAISE once the old gate reports off. SW_RAISE goes to SW_IDLE, committing the new code, once the new gate reports on.

The block also holds the system post-divider (the divide ratio is the code plus one). The slew machine has two states. SL_IDLE either applies a new target at once, or moves to SL_WAIT when stepping is enabled for that direction. SL_WAIT moves the applied code one step per wait period and returns to SL_IDLE when the applied code reaches the target. The key gate has three states. LK_SHUT goes to LK_ARMED on the first key. LK_ARMED goes to LK_OPEN on the second key and back to LK_SHUT on any other write. LK_OPEN goes to LK_SHUT, or to LK_ARMED if the first key is written, on any write to the key or spare address.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the control readback and the slew readback are all zero, and `sys_clk_o` follows source 0.
- R2: Writes to the control word (address 0) or the slew word (address 1) take effect only after the first key 32'h5A3C_C3A5 and then the second key 32'hA5C3_3C5A are written to address 2 on consecutive writes. Any other sequence leaves both words unchanged.
- R3: While the gate is open, a write of any value other than the first key to address 2 or 3 shuts the gate again, and later register writes are ignored.
- R4: A control write with bit 0 set and a code in bits 10:8 starts a switch. Bit 0 reads 1 until the attempt ends and then clears by itself. On success, bits 14:12 show the new code.
- R5: If the requested source's ready input is low, the attempt is refused: bit 0 clears and bits 14:12 keep their old value.
- R6: After a successful switch, `sys_clk_o` has the period of the newly selected source.
- R7: A control write that arrives while bit 0 reads 1 has no effect on the requested code or on the switch.
- R8: The slew word reads the target post-divider code in bits 23:20 and the applied code on `div_code_o`. With stepping disabled for the needed direction, the applied code equals the target one cycle after the write.
- R9: Bit 2 enables stepping when the code decreases, and bit 1 enables it when the code increases. When stepping is enabled, the applied code moves by one every (field[10:8]+1)*4 cycles.
- R10: Slew-word bit 0 (busy) reads 1 from the write that changes the target until the applied code equals the target, throughout a stepped sequence.
- R11: A request for the source that is already current completes without changing bits 14:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 8 | Oscillator source clocks |
| src_rdy_i | input | 8 | Per-source ready flags (asynchronous) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | 0 control, 1 slew, 2 key, 3 spare |
| wr_data_i | input | 32 | Write data |
| ctrl_rd_o | output | 32 | Control readback: [14:12] current, [10:8] requested, [0] start/busy |
| slew_rd_o | output | 32 | Slew readback: [23:20] target, [10:8] step, [2] up enable, [1] down enable, [0] busy |
| div_code_o | output | 4 | Applied post-divider code |
| sys_clk_o | output | 1 | Glitch-free selected system clock |

## Verification
The switch is driven in four ways: a change to a ready source, a change to a source held not-ready, a request for the already-current source, and a second request written while one is in flight. The results separate a committed switch, a refusal, a trivial completion and an ignored write. For each committed switch, the output period is measured on the new source. The post-divider is moved once with no stepping, once upward with only the down-enable set, once downward with only the up-enable set, and once in a direction whose enable is clear. The busy-cycle counts tell a stepped move from a direct jump. Key writes are tried in the correct order, with a register write between the keys, and with a relocking write. This shows that only the exact pair opens the registers.

// File: rtl/sysclk_switch_pkg.sv
`timescale 1ns/1ps
package sysclk_switch_pkg;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = 4;
    localparam int STEP_W = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_SLEW = 2'd1;
    localparam logic [1:0] A_KEY  = 2'd2;

    localparam logic [31:0] KEY_FIRST  = 32'h5A3C_C3A5;
    localparam logic [31:0] KEY_SECOND = 32'hA5C3_3C5A;

    typedef enum logic [1:0] {LK_SHUT, LK_ARMED, LK_OPEN} lock_e;
    typedef enum logic [1:0] {SW_IDLE, SW_CHECK, SW_DROP, SW_RAISE} sw_e;
    typedef enum logic {SL_IDLE, SL_WAIT} slew_e;
endpackage

// File: rtl/sysclk_unlock.sv
`timescale 1ns/1ps
module sysclk_unlock
    import sysclk_switch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    output logic        open_o
);
    lock_e st_q, st_d;
    logic  key_a, key_b, off_reg;

    assign key_a   = (wr_addr_i == A_KEY) && (wr_data_i == KEY_FIRST);
    assign key_b   = (wr_addr_i == A_KEY) && (wr_data_i == KEY_SECOND);
    assign off_reg = wr_addr_i[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_SHUT:  if (wr_en_i && key_a) st_d = LK_ARMED;
            LK_ARMED: if (wr_en_i) st_d = key_b ? LK_OPEN : LK_SHUT;
            LK_OPEN:  if (wr_en_i && off_reg) st_d = key_a ? LK_ARMED : LK_SHUT;
        endcase
    end

    assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/sysclk_gate.sv
`timescale 1ns/1ps
module sysclk_gate #(
    parameter bit RESET_ON = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_clk_i,
    input  logic en_i,
    output logic gclk_o,
    output logic ack_o
);
    logic s1_q, s2_q, gate_q, a1_q, a2_q;

    always_ff @(posedge src_clk_i or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RESET_ON;
            s2_q <= RESET_ON;
        end else begin
            s1_q <= en_i;
            s2_q <= s1_q;
        end
    end

    // gate changes only while the source is low
    always_ff @(negedge src_clk_i or negedge rst_n) begin
        if (!rst_n) gate_q <= RESET_ON;
        else        gate_q <= s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a1_q <= RESET_ON;
            a2_q <= RESET_ON;
        end else begin
            a1_q <= gate_q;
            a2_q <= a1_q;
        end
    end

    assign gclk_o = src_clk_i & gate_q;
    assign ack_o  = a2_q;
endmodule

// File: rtl/sysclk_slew.sv
`timescale 1ns/1ps
module sysclk_slew
    import sysclk_switch_pkg::*;
#(
    parameter int STEP_UNIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DIV_W-1:0]  wr_div_i,
    input  logic [STEP_W-1:0] wr_step_i,
    input  logic              wr_up_i,
    input  logic              wr_dn_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [31:0]       rd_o
);
    localparam int CNT_W = $clog2(STEP_UNIT * (2 ** STEP_W)) + 1;

    slew_e             st_q, st_d;
    logic [DIV_W-1:0]  tgt_q, cur_q, toward;
    logic [STEP_W-1:0] step_q;
    logic              up_q, dn_q, slew_ok, at_end, busy;
    logic [CNT_W-1:0]  cnt_q, wait_len;

    assign wait_len = CNT_W'((int'(step_q) + 1) * STEP_UNIT);
    assign toward   = (tgt_q > cur_q) ? cur_q + 1'b1 : cur_q - 1'b1;
    assign slew_ok  = (tgt_q < cur_q) ? up_q : dn_q;
    assign at_end   = (cnt_q == wait_len - 1'b1);
    assign busy     = (cur_q != tgt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SL_IDLE: if (busy && slew_ok) st_d = SL_WAIT;
            SL_WAIT: if (!busy || (at_end && toward == tgt_q)) st_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SL_IDLE: begin
                    cnt_q <= '0;
                    if (busy && !slew_ok) cur_q <= tgt_q;
                end
                SL_WAIT: begin
                    if (busy) begin
                        if (at_end) begin
                            cur_q <= toward;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            step_q <= '0;
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
        end else if (wr_i) begin
            tgt_q  <= wr_div_i;
            step_q <= wr_step_i;
            up_q   <= wr_up_i;
            dn_q   <= wr_dn_i;
        end
    end

    assign div_o = cur_q;
    assign rd_o  = {8'b0, tgt_q, 9'b0, step_q, 5'b0, up_q, dn_q, busy};

    // R9
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_WAIT) |=> (cur_q == $past(cur_q) ||
                               cur_q == $past(cur_q) + 1'b1 ||
                               cur_q == $past(cur_q) - 1'b1));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
    import sysclk_switch_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int RESET_SRC = 0,
    parameter int STEP_UNIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_clk_i,
    input  logic [N_SRC-1:0] src_rdy_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [31:0]      wr_data_i,
    output logic [31:0]      ctrl_rd_o,
    output logic [31:0]      slew_rd_o,
    output logic [DIV_W-1:0] div_code_o,
    output logic             sys_clk_o
);
    localparam logic [N_SRC-1:0] EN_RST = N_SRC'(1) << RESET_SRC;

    sw_e              sw_q, sw_d;
    logic [SEL_W-1:0] cosc_q, nosc_q;
    logic             swen_q, open, ctrl_wr, slew_wr, new_rdy;
    logic [N_SRC-1:0] en_req_q, ack, gclk, rdy_m_q, rdy_s_q;

    sysclk_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .open_o(open)
    );

    assign ctrl_wr = wr_en_i && open && (wr_addr_i == A_CTRL);
    assign slew_wr = wr_en_i && open && (wr_addr_i == A_SLEW);

    sysclk_slew #(.STEP_UNIT(STEP_UNIT)) u_slew (
        .clk(clk), .rst_n(rst_n), .wr_i(slew_wr),
        .wr_div_i(wr_data_i[23:20]), .wr_step_i(wr_data_i[10:8]),
        .wr_up_i(wr_data_i[2]), .wr_dn_i(wr_data_i[1]),
        .div_o(div_code_o), .rd_o(slew_rd_o)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        sysclk_gate #(.RESET_ON(g == RESET_SRC)) u_gate (
            .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk_i[g]),
            .en_i(en_req_q[g]), .gclk_o(gclk[g]), .ack_o(ack[g])
        );
    end

    assign sys_clk_o = |gclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_m_q <= '0;
            rdy_s_q <= '0;
        end else begin
            rdy_m_q <= src_rdy_i;
            rdy_s_q <= rdy_m_q;
        end
    end

    assign new_rdy = rdy_s_q[nosc_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= SW_IDLE;
        else        sw_q <= sw_d;
    end

    always_comb begin
        sw_d = sw_q;
        unique case (sw_q)
            SW_IDLE:  if (ctrl_wr && wr_data_i[0]) sw_d = SW_CHECK;
            SW_CHECK: sw_d = (!new_rdy || nosc_q == cosc_q) ? SW_IDLE : SW_DROP;
            SW_DROP:  if (!ack[cosc_q]) sw_d = SW_RAISE;
            SW_RAISE: if (ack[nosc_q]) sw_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cosc_q   <= SEL_W'(RESET_SRC);
            nosc_q   <= SEL_W'(RESET_SRC);
            swen_q   <= 1'b0;
            en_req_q <= EN_RST;
        end else begin
            unique case (sw_q)
                SW_IDLE: if (ctrl_wr) begin
                    nosc_q <= wr_data_i[10:8];
                    swen_q <= wr_data_i[0];
                end
                SW_CHECK: begin
                    if (!new_rdy || nosc_q == cosc_q) swen_q <= 1'b0;
                    else en_req_q[cosc_q] <= 1'b0;
                end
                SW_DROP: if (!ack[cosc_q]) en_req_q[nosc_q] <= 1'b1;
                SW_RAISE: if (ack[nosc_q]) begin
                    cosc_q <= nosc_q;
                    swen_q <= 1'b0;
                end
            endcase
        end
    end

    assign ctrl_rd_o = {17'b0, cosc_q, 1'b0, nosc_q, 7'b0, swen_q};

    // R4
    commit_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cosc_q) |-> $fell(swen_q));
    // R5
    refuse_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q == SW_CHECK && !new_rdy) |=> ($stable(cosc_q) && !swen_q));
    // R2
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !open && wr_addr_i == A_CTRL) |=> $stable(nosc_q));
    // R6
    one_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_req_q));
endmodule

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
module sysclk_switch_bench;
    localparam logic [31:0] KA = 32'h5A3C_C3A5;
    localparam logic [31:0] KB = 32'hA5C3_3C5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    wire  [7:0]  src_clk;
    logic [7:0]  src_rdy = 8'b1101_1111;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] ctrl_rd, slew_rd;
    logic [3:0]  div_code;
    logic        sys_clk;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < 8; g++) begin : g_src
        logic s = 1'b0;
        initial forever #(3.0 + g) s = ~s;
        assign src_clk[g] = s;
    end

    sysclk_switch u_sysclk_switch (
        .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk), .src_rdy_i(src_rdy),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ctrl_rd_o(ctrl_rd), .slew_rd_o(slew_rd), .div_code_o(div_code),
        .sys_clk_o(sys_clk)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference of the register side
    int m_lock = 0, m_nosc = 0, m_tgt = 0, m_cur = 0, m_step = 0;
    int m_up = 0, m_dn = 0, m_ph = 0, m_cnt = 0;
    bit swen_s = 1'b0;
    bit live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_nosc = 0; m_tgt = 0; m_cur = 0; m_step = 0;
            m_up = 0; m_dn = 0; m_ph = 0; m_cnt = 0;
        end else begin
            bit admit;
            int w;
            admit = wr_en && m_lock == 2 && wr_addr < 2;
            w = (m_step + 1) * 4;
            if (m_ph == 0) begin
                if (m_tgt != m_cur) begin
                    if ((m_tgt < m_cur && m_up != 0) || (m_tgt > m_cur && m_dn != 0)) begin
                        m_ph = 1; m_cnt = 0;
                    end else m_cur = m_tgt;
                end
            end else if (m_tgt == m_cur) begin
                m_ph = 0;
            end else if (m_cnt == w - 1) begin
                m_cur = m_cur + ((m_tgt > m_cur) ? 1 : -1);
                m_cnt = 0;
                if (m_cur == m_tgt) m_ph = 0;
            end else m_cnt++;
            if (admit && wr_addr == 1) begin
                m_tgt = wr_data[23:20]; m_step = wr_data[10:8];
                m_up = wr_data[2]; m_dn = wr_data[1];
            end
            if (admit && wr_addr == 0 && !swen_s) m_nosc = wr_data[10:8];
            if (wr_en) begin
                case (m_lock)
                    0: if (wr_addr == 2 && wr_data == KA) m_lock = 1;
                    1: m_lock = (wr_addr == 2 && wr_data == KB) ? 2 : 0;
                    default: if (wr_addr >= 2) m_lock = (wr_addr == 2 && wr_data == KA) ? 1 : 0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            logic [31:0] exp_slew;
            exp_slew = {8'b0, 4'(m_tgt), 9'b0, 3'(m_step), 5'b0, 1'(m_up), 1'(m_dn),
                        1'(m_tgt != m_cur)};
            // R8 R10 per-cycle slew word and applied code
            chk(slew_rd == exp_slew && div_code == 4'(m_cur), "R8/R10 slew",
                {slew_rd, 4'b0, div_code}, {exp_slew, 4'b0, 4'(m_cur)});
            // R2 R7 requested field
            chk(ctrl_rd[10:8] == 3'(m_nosc), "R2/R7 requested code", ctrl_rd[10:8], m_nosc);
        end
        swen_s = ctrl_rd[0];
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd2, KA);
        wr(2'd2, KB);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 300; i++) begin
            if (!ctrl_rd[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic period(input real exp, input string req);
        realtime t0, d;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); d = $realtime - t0;
        chk(d > exp - 0.5 && d < exp + 0.5, req, longint'(d * 1000), longint'(exp * 1000));
    endtask

    task automatic busy_count(input int exp, input string req);
        int n = 0;
        for (int i = 0; i < 400; i++) begin
            if (!slew_rd[0]) break;
            n++;
            @(negedge clk);
        end
        chk(n == exp, req, n, exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        // R1
        chk(ctrl_rd == 32'd0, "R1 control reset", ctrl_rd, 0);
        chk(slew_rd == 32'd0, "R1 slew reset", slew_rd, 0);
        period(6.0, "R1 source 0 period");

        // R2 locked write, then a write between the keys
        wr(2'd0, 32'h0000_0301);
        wr(2'd2, KA);
        wr(2'd0, 32'h0000_0301);
        wr(2'd2, KB);
        wr(2'd0, 32'h0000_0301);
        repeat (3) @(negedge clk);
        chk(ctrl_rd == 32'd0, "R2 writes without key pair", ctrl_rd, 0);

        // R4 R6 switch to ready source 3
        unlock();
        wr(2'd0, 32'h0000_0301);
        chk(ctrl_rd[0] == 1'b1, "R4 start bit set", ctrl_rd[0], 1);
        wait_done();
        chk(ctrl_rd[14:12] == 3'd3 && !ctrl_rd[0], "R4 current code", ctrl_rd, 32'h3300);
        period(12.0, "R6 source 3 period");

        // R7 second request during a switch
        wr(2'd0, 32'h0000_0201);
        wr(2'd0, 32'h0000_0701);
        wait_done();
        chk(ctrl_rd == 32'h0000_2200, "R7 in-flight write ignored", ctrl_rd, 32'h2200);
        period(10.0, "R6 source 2 period");

        // R5 refused: source 5 not ready
        wr(2'd0, 32'h0000_0501);
        wait_done();
        chk(ctrl_rd == 32'h0000_2500, "R5 refused keeps current", ctrl_rd, 32'h2500);
        period(10.0, "R5 clock unchanged");

        // R11 same source
        wr(2'd0, 32'h0000_0201);
        wait_done();
        chk(ctrl_rd == 32'h0000_2200, "R11 same source", ctrl_rd, 32'h2200);

        // R3 relock
        wr(2'd2, 32'h0000_0000);
        wr(2'd0, 32'h0000_0101);
        repeat (2) @(negedge clk);
        chk(ctrl_rd == 32'h0000_2200, "R3 relocked", ctrl_rd, 32'h2200);

        // R8 direct post-divider change
        unlock();
        wr(2'd1, 32'h0050_0000);
        chk(slew_rd[0] == 1'b1, "R8 busy after write", slew_rd[0], 1);
        @(negedge clk);
        chk(div_code == 4'd5 && !slew_rd[0], "R8 applied next cycle", div_code, 5);

        // R9 R10 stepped increase, down-enable, step field 1
        wr(2'd1, 32'h0070_0102);
        busy_count(17, "R9/R10 stepped increase");
        chk(div_code == 4'd7, "R9 increase end", div_code, 7);

        // R9 R10 stepped decrease, up-enable, step field 0
        wr(2'd1, 32'h0010_0004);
        busy_count(25, "R9/R10 stepped decrease");
        chk(div_code == 4'd1, "R9 decrease end", div_code, 1);

        // R9 increase with only up-enable: direct jump
        wr(2'd1, 32'h0040_0004);
        busy_count(1, "R9 jump when direction disabled");
        chk(div_code == 4'd4, "R9 jump value", div_code, 4);

        repeat (4) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule